// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product using a single N-bit adder. Alongside the adder it keeps four registers: one for the multiplicand, an accumulator, a carry flop, and a multiplier register whose contents are shifted out one bit at a time. As the multiplier bits leave that register, it fills with the low half of the product.

A small controller handles each multiplier bit in three clock cycles. In the first cycle, if the multiplier's current low bit is set, the controller adds the multiplicand into the accumulator and keeps the carry-out. In the second cycle, it shifts the carry, accumulator and multiplier register right by one bit as a single chain, with a zero entering at the top. In the third cycle, it decrements a step counter and tests the new value for zero. A host pulses `start` with operands `x` (the multiplier) and `y` (the multiplicand) while the block is idle. It then waits for `done` and reads `product`, which stays valid until the next accepted start. The default width is 32. Setting the width to 4 makes the steps easy to trace by hand.

Top module: `shadd_mult`

## Requirements
- R1: After a synchronous active-high reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: When `start` is 1 while `busy` is 0, the block captures `x` and `y` at that clock edge, and `busy` is 1 in the following cycle.
- R3: `done` is high for exactly one cycle, in the cycle that follows 3N+1 clock edges counted from the edge that accepted start. In that cycle, `busy` is 0. Before that cycle, `busy` is high for the 3N cycles that follow the accepting edge.
- R4: When `done` is high, `product` equals the unsigned product x*y. The upper N bits come from the accumulator and the lower N bits from the multiplier register.
- R5: The latency in R3 is the same for every operand pair, whatever the number of zero bits in the multiplier.
- R6: A `start` pulse, and any change on `x` or `y`, while `busy` is 1 has no effect on the product or on the timing of the operation in progress.
- R7: While idle, `product` holds its last value until the next accepted start.
- R8: Zero operands give a zero product. For N=4, the operands 1111 × 1111 give 11100001, and every all-ones pair gives the full-width result.
- R9: A start presented in the same cycle that `done` is high is accepted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply; only accepted while idle |
| x | input | N | Multiplier operand, unsigned |
| y | input | N | Multiplicand operand, unsigned |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Result: accumulator as the high half, multiplier register as the low half |

## Verification
The bench counts clock edges. For every accepted start, it computes the cycle in which `done` must appear: 3N+1 edges after the accepting edge. It also checks that `busy` is high one edge after acceptance. When the bench issues a request, it queues the expected product together with the due cycle. A monitor samples on the falling clock edge, so each observation falls between edges. It then compares both the value and the arrival cycle, so a result that is correct but early or late still counts as a failure. Stimulus covering R6 changes the operands and pulses start in the middle of an operation, while the queued expectation keeps the original operands and due cycle. Stimulus covering R7 samples `product` again several idle cycles after `done`.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ADD   = 2'd1,
      PH_SHIFT = 2'd2,
      PH_COUNT = 2'd3
   } phase_t;
endpackage

// File: rtl/shadd_adder.sv
module shadd_adder #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign cout = cy[W];
      end else begin : g_behav
         logic [W:0] full;
         assign full = {1'b0, a} + {1'b0, b};
         assign sum  = full[W-1:0];
         assign cout = full[W];
      end
   endgenerate
endmodule

// File: rtl/shadd_ctrl.sv
module shadd_ctrl
   import shadd_pkg::*;
#(
   parameter int N = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic do_add,
   output logic do_shift,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(N + 1);
   localparam logic [CW-1:0] STEPS = CW'(N);
   localparam logic [CW-1:0] LAST  = CW'(1);

   phase_t        phase;
   logic [CW-1:0] steps_left;
   logic          done_q;

   assign load     = (phase == PH_IDLE) && start;
   assign do_add   = (phase == PH_ADD);
   assign do_shift = (phase == PH_SHIFT);
   assign busy     = (phase != PH_IDLE);
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase      <= PH_IDLE;
         steps_left <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase      <= PH_ADD;
                  steps_left <= STEPS;
               end
            end
            PH_ADD:   phase <= PH_SHIFT;
            PH_SHIFT: phase <= PH_COUNT;
            PH_COUNT: begin
               steps_left <= steps_left - LAST;
               if (steps_left == LAST) begin
                  phase  <= PH_IDLE;
                  done_q <= 1'b1;
               end else begin
                  phase <= PH_ADD;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/shadd_datapath.sv
module shadd_datapath #(
   parameter int N      = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           do_add,
   input  logic           do_shift,
   input  logic [N-1:0]   x,
   input  logic [N-1:0]   y,
   output logic [2*N-1:0] product
);
   logic         cflag;
   logic [N-1:0] acc;
   logic [N-1:0] mcand;
   logic [N-1:0] mplier;
   logic [N-1:0] add_sum;
   logic         add_cout;

   shadd_adder #(.W(N), .RIPPLE(RIPPLE)) u_add (
      .a    (acc),
      .b    (mcand),
      .sum  (add_sum),
      .cout (add_cout)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cflag  <= 1'b0;
         acc    <= '0;
         mcand  <= '0;
         mplier <= '0;
      end else if (load) begin
         cflag  <= 1'b0;
         acc    <= '0;
         mcand  <= y;
         mplier <= x;
      end else if (do_add) begin
         if (mplier[0]) begin
            cflag <= add_cout;
            acc   <= add_sum;
         end
      end else if (do_shift) begin
         cflag  <= 1'b0;
         acc    <= {cflag, acc[N-1:1]};
         mplier <= {acc[0], mplier[N-1:1]};
      end
   end

   assign product = {acc, mplier};
endmodule

// File: rtl/shadd_mult.sv
module shadd_mult #(
   parameter int N             = 32,
   parameter bit RIPPLE_ADDER  = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [N-1:0]   x,
   input  logic [N-1:0]   y,
   output logic           busy,
   output logic           done,
   output logic [2*N-1:0] product
);
   generate
      if (N < 2) begin : g_bad_width
         $error("shadd_mult: N must be at least 2");
      end
   endgenerate

   logic load;
   logic do_add;
   logic do_shift;

   shadd_ctrl #(.N(N)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .load     (load),
      .do_add   (do_add),
      .do_shift (do_shift),
      .busy     (busy),
      .done     (done)
   );

   shadd_datapath #(.N(N), .RIPPLE(RIPPLE_ADDER)) u_dp (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .do_add   (do_add),
      .do_shift (do_shift),
      .x        (x),
      .y        (y),
      .product  (product)
   );
endmodule

// File: rtl/shadd_mult_chk.sv
module shadd_mult_chk #(
   parameter int N = 32
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic [N-1:0]   x,
   input logic [N-1:0]   y,
   input logic           busy,
   input logic           done,
   input logic [2*N-1:0] product
);
   localparam int unsigned LAT = 3 * N;

   int unsigned    busy_cycles;
   logic [2*N-1:0] expect_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_cycles <= 0;
         expect_q    <= '0;
      end else if (start && !busy) begin
         busy_cycles <= 0;
         expect_q    <= {{N{1'b0}}, x} * {{N{1'b0}}, y};
      end else if (busy) begin
         busy_cycles <= busy_cycles + 1;
      end
   end

   a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !done && product == '0));
   a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
   a_r3_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
   a_r5_fixed_latency: assert property (@(posedge clk) disable iff (rst) done |-> (busy_cycles == LAT));
   a_r4_product_value: assert property (@(posedge clk) disable iff (rst) done |-> (product == expect_q));
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(product));
endmodule

bind shadd_mult shadd_mult_chk #(.N(N)) u_chk (.*);

// File: tb/sim_shadd_mult.sv
module sim_shadd_mult;
   localparam int W   = 4;
   localparam int LAT = 3 * W + 1;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [W-1:0]   x = '0;
   logic [W-1:0]   y = '0;
   logic           busy;
   logic           done;
   logic [2*W-1:0] product;

   int unsigned cyc = 0;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;

   logic [2*W-1:0] exp_q[$];
   int unsigned    due_q[$];

   shadd_mult #(.N(W)) u0 (
      .clk(clk), .rst(rst), .start(start), .x(x), .y(y),
      .busy(busy), .done(done), .product(product)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // driver: waits until idle, issues start, queues the expectation
   task automatic mul(input logic [W-1:0] a, input logic [W-1:0] b);
      while (busy) @(negedge clk);
      x = a; y = b; start = 1'b1;
      exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
      due_q.push_back(cyc + 1 + 3 * W);
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy after accept", busy, 1);
   endtask

   // monitor: compares value and arrival cycle of each result
   always @(negedge clk) begin
      if (!rst && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected done", 1, 0);
         end else begin
            logic [2*W-1:0] e;
            int unsigned    d;
            e = exp_q.pop_front();
            d = due_q.pop_front();
            check(product == e, "R4 product", product, e);
            check(cyc == d, "R3 R5 done cycle", cyc, d);
            check(busy == 1'b0, "R3 busy low with done", busy, 0);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
      check(product == 0, "R1 reset product", product, 0);

      // R8 corner operands
      mul(4'hF, 4'hF);
      while (busy) @(negedge clk);
      check(product == 8'hE1, "R8 all-ones", product, 8'hE1);
      mul(4'h0, 4'h0);
      mul(4'h0, 4'hF);
      mul(4'hF, 4'h0);

      // R7 hold while idle
      mul(4'hB, 4'h7);
      while (busy) @(negedge clk);
      repeat (6) @(negedge clk);
      x = 4'h3; y = 4'h5;
      @(negedge clk);
      check(product == 8'd77, "R7 hold", product, 77);

      // R6 start and operand changes while busy are ignored
      mul(4'h9, 4'hD);
      repeat (4) @(negedge clk);
      x = 4'h1; y = 4'h2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; x = 4'hF;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      check(product == 8'd117, "R6 ignored start", product, 117);

      // R9 back-to-back: driver issues next start in the done cycle
      mul(4'h6, 4'h6);
      while (!done) @(negedge clk);
      mul(4'h5, 4'hA);

      // R4 R5 exhaustive sweep, back to back
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            mul(a[W-1:0], b[W-1:0]);
      while (busy || exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R3 all results arrived", exp_q.size(), 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R3 watchdog expired: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule